// File: doc/BRIEF.md
# UART Interrupt Priority and Identification Logic

This block decides which of five interrupt causes in a 16550-style serial port register file is reported to the host, and drives the interrupt request line. It takes the interrupt enable bits, the line status bits, the receive FIFO fill count and trigger level, the FIFO enable flag, a character-timeout pending flag and the modem status change bits. It also owns the one piece of interrupt state that lives in this logic: the "transmit holding register empty" pending flag. That flag is set by an event from the transmitter, set again by a write to the enable register while the holding register is empty, and cleared by a write to the holding register or by a host read of the identification byte while it shows the transmit-empty cause.

The identification byte is combinational from the current inputs and the pending flag, so a read strobe returns the value computed before any clear that the read causes. The request line is registered from the same computation and follows it one clock later. FIFO storage, the serializer, the baud generator and the register decode sit outside the block and reach it as plain inputs.

Top module: `uart_irq_ident`

## Requirements
- R1: During and right after a synchronous active-low reset, with no cause active and FIFOs disabled, `iir_o` reads 0x01, `irq_o` is 0 and the transmit-empty pending flag is clear.
- R2: When several causes are active and enabled, the reported one is the first in this order: line status, character timeout, receive data, transmit empty, modem status.
- R3: The low nibble of `iir_o` is 0x6 for line status, 0xC for timeout, 0x4 for receive data, 0x2 for transmit empty, 0x0 for modem status, and 0x1 when no enabled cause is active; bits 5:4 read 0.
- R4: A line status cause is active when `ier_i[2]` is 1 and any of `line_stat_i[4:1]` (overrun, parity, framing, break) is 1; `line_stat_i[0]` (data ready) alone does not raise it.
- R5: The character timeout cause is active when `tmo_pend_i` is 1 and `ier_i[0]` is 1; with `ier_i[0]` at 0 the timeout is not reported.
- R6: The receive data cause needs `ier_i[0]` and `line_stat_i[0]`; with `fifo_en_i` at 1 it also needs `rx_count_i >= rx_trig_i`, with `fifo_en_i` at 0 data ready is enough.
- R7: A `tx_set_i` pulse sets the transmit-empty pending flag on the next edge, a `thr_wr_i` pulse clears it, a set wins over a clear in the same cycle, and the flag is reported only while `ier_i[1]` is 1.
- R8: An `iir_rd_i` strobe in a cycle where `iir_o` shows 0x2 returns 0x2 in that cycle and clears the pending flag at the next edge; a strobe while a higher cause is shown leaves the flag set.
- R9: An `ier_wr_i` pulse while `tx_hold_empty_i` is 1 sets the pending flag; with `tx_hold_empty_i` at 0 it leaves the flag unchanged.
- R10: Bits 7:6 of `iir_o` read 2'b11 when `fifo_en_i` is 1 and 2'b00 otherwise, whatever the cause.
- R11: `irq_o` equals 1 exactly when the low nibble of `iir_o` was not 0x1 in the previous clock cycle.
- R12: The modem status cause is active when `ier_i[3]` is 1 and any bit of `msr_delta_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ier_i | input | 4 | Enables: bit0 receive data and timeout, bit1 transmit empty, bit2 line status, bit3 modem status |
| ier_wr_i | input | 1 | One-cycle strobe: the enable register was written |
| line_stat_i | input | 5 | bit0 data ready, bit1 overrun, bit2 parity, bit3 framing, bit4 break |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive FIFO trigger level |
| fifo_en_i | input | 1 | FIFOs enabled |
| tmo_pend_i | input | 1 | Character timeout pending |
| tx_set_i | input | 1 | One-cycle strobe: transmit holding register became empty |
| tx_hold_empty_i | input | 1 | Transmit holding register is empty (level) |
| thr_wr_i | input | 1 | One-cycle strobe: holding register was written |
| msr_delta_i | input | 4 | Modem status change bits |
| iir_rd_i | input | 1 | One-cycle strobe: host reads the identification byte |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The identification byte reflects a change of any plain input in the same cycle, a pending-flag event one edge after its strobe, and the request line one edge after the identification byte. The sweep therefore applies each combination, lets the pending flag settle through its strobe cycles, and samples both outputs on the falling edge that follows the next rising edge. The read-clear case samples the byte in the strobe cycle itself and the cleared value one edge later, and a separate check samples the request line in the half cycle before its edge to confirm the one-cycle lag.

// File: rtl/uart_irq_pkg.sv
// Shared constants for the UART interrupt identifier.
// Assumes cause index 0 is the highest priority.
package uart_irq_pkg;

    localparam int NUM_SRC = 5;

    localparam logic [3:0] ID_NONE  = 4'h1;
    localparam logic [3:0] ID_LINE  = 4'h6;
    localparam logic [3:0] ID_TMO   = 4'hC;
    localparam logic [3:0] ID_RXD   = 4'h4;
    localparam logic [3:0] ID_THRE  = 4'h2;
    localparam logic [3:0] ID_MODEM = 4'h0;

    // Identification code for a cause index in priority order.
    function automatic logic [3:0] src_id(input int idx);
        case (idx)
            0:       return ID_LINE;
            1:       return ID_TMO;
            2:       return ID_RXD;
            3:       return ID_THRE;
            default: return ID_MODEM;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_qual.sv
// Qualifies the five interrupt causes against their enables.
// Output req is in priority order, index 0 highest.
// Assumes the transmit-empty pending flag is supplied by uart_irq_thre.
module uart_irq_qual
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          ier_i,
    input  logic [4:0]          line_stat_i,
    input  logic [CNT_W-1:0]    rx_count_i,
    input  logic [CNT_W-1:0]    rx_trig_i,
    input  logic                fifo_en_i,
    input  logic                tmo_pend_i,
    input  logic                thre_pend_i,
    input  logic [3:0]          msr_delta_i,
    output logic [NUM_SRC-1:0]  req_o
);

    logic err_any;
    logic rx_level_ok;

    // Build the qualified request vector from the raw conditions.
    always_comb begin
        err_any     = |line_stat_i[4:1];
        rx_level_ok = !fifo_en_i || (rx_count_i >= rx_trig_i);
        req_o[0]    = ier_i[2] && err_any;
        req_o[1]    = ier_i[0] && tmo_pend_i;
        req_o[2]    = ier_i[0] && line_stat_i[0] && rx_level_ok;
        req_o[3]    = ier_i[1] && thre_pend_i;
        req_o[4]    = ier_i[3] && (|msr_delta_i);
    end

    // R5
    tmo_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ier_i[0]) |-> (!req_o[1] && !req_o[2]));

    // R12
    modem_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_i[3] && msr_delta_i != 4'h0) |-> req_o[4]);

endmodule

// File: rtl/uart_irq_prio.sv
// Fixed priority encoder: picks the lowest-index active request
// and returns its identification code, or ID_NONE when idle.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] req_i,
    output logic [3:0]   id_o
);

    logic [N-1:0] grant;

    // One grant per cause, blocked by any higher-priority request.
    for (genvar g = 0; g < N; g++) begin : g_gnt
        if (g == 0) begin : g_top
            assign grant[g] = req_i[g];
        end else begin : g_rest
            assign grant[g] = req_i[g] & ~(|req_i[g-1:0]);
        end
    end

    // Map the single grant onto its code.
    always_comb begin
        id_o = ID_NONE;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) id_o = src_id(i);
        end
    end

endmodule

// File: rtl/uart_irq_thre.sv
// Transmit-empty pending flag. Set events win over clear events.
// Assumes all strobes are one clock wide.
module uart_irq_thre (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_set_i,
    input  logic ier_wr_i,
    input  logic tx_hold_empty_i,
    input  logic thr_wr_i,
    input  logic iir_rd_i,
    input  logic id_is_thre_i,
    output logic pend_o
);

    logic set_evt;
    logic clr_evt;

    // Decode the set and clear events for this cycle.
    always_comb begin
        set_evt = tx_set_i || (ier_wr_i && tx_hold_empty_i);
        clr_evt = thr_wr_i || (iir_rd_i && id_is_thre_i);
    end

    // Hold the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_o <= 1'b0;
        else if (set_evt) pend_o <= 1'b1;
        else if (clr_evt) pend_o <= 1'b0;
    end

    // R7
    thre_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_set_i |=> pend_o);

    // R9
    ier_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_wr_i && tx_hold_empty_i) |=> pend_o);

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd_i && id_is_thre_i && !tx_set_i && !ier_wr_i) |=> !pend_o);

endmodule

// File: rtl/uart_irq_ident.sv
// Top of the UART interrupt identifier: qualifies causes, encodes
// the winning one into the identification byte and registers the
// request line. Assumes a synchronous active-low reset.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ier_i,
    input  logic             ier_wr_i,
    input  logic [4:0]       line_stat_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic [CNT_W-1:0] rx_trig_i,
    input  logic             fifo_en_i,
    input  logic             tmo_pend_i,
    input  logic             tx_set_i,
    input  logic             tx_hold_empty_i,
    input  logic             thr_wr_i,
    input  logic [3:0]       msr_delta_i,
    input  logic             iir_rd_i,
    output logic [7:0]       iir_o,
    output logic             irq_o
);

    logic [NUM_SRC-1:0] req;
    logic [3:0]         id;
    logic               thre_pend;
    logic               irq_q;

    uart_irq_thre u_thre (
        .clk             (clk),
        .rst_n           (rst_n),
        .tx_set_i        (tx_set_i),
        .ier_wr_i        (ier_wr_i),
        .tx_hold_empty_i (tx_hold_empty_i),
        .thr_wr_i        (thr_wr_i),
        .iir_rd_i        (iir_rd_i),
        .id_is_thre_i    (id == ID_THRE),
        .pend_o          (thre_pend)
    );

    uart_irq_qual #(.CNT_W(CNT_W)) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .ier_i       (ier_i),
        .line_stat_i (line_stat_i),
        .rx_count_i  (rx_count_i),
        .rx_trig_i   (rx_trig_i),
        .fifo_en_i   (fifo_en_i),
        .tmo_pend_i  (tmo_pend_i),
        .thre_pend_i (thre_pend),
        .msr_delta_i (msr_delta_i),
        .req_o       (req)
    );

    uart_irq_prio #(.N(NUM_SRC)) u_prio (
        .req_i (req),
        .id_o  (id)
    );

    // Assemble the identification byte with the FIFO marker bits.
    always_comb begin
        iir_o = {fifo_en_i ? 2'b11 : 2'b00, 2'b00, id};
    end

    // Register the request line from the current identification.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (id != ID_NONE);
    end

    assign irq_o = irq_q;

    // R11
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_o == ($past(iir_o[3:0]) != ID_NONE)));

    // R4
    line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_i[2] && line_stat_i[4:1] != 4'h0) |-> (iir_o[3:0] == ID_LINE));

    // R10
    fifo_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iir_o[7:6] == {2{fifo_en_i}});

    // R2
    tmo_over_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_i[0] && tmo_pend_i && !(ier_i[2] && line_stat_i[4:1] != 4'h0))
        |-> (iir_o[3:0] == ID_TMO));

endmodule

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;

    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       ier = 4'h0;
    logic             ier_wr = 1'b0;
    logic [4:0]       lstat = 5'h0;
    logic [CNT_W-1:0] cnt = '0;
    logic [CNT_W-1:0] trig = 5'd8;
    logic             fifo_en = 1'b0;
    logic             tmo = 1'b0;
    logic             tx_set = 1'b0;
    logic             hold_empty = 1'b0;
    logic             thr_wr = 1'b0;
    logic [3:0]       delta = 4'h0;
    logic             iir_rd = 1'b0;
    logic [7:0]       iir;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .ier_i(ier), .ier_wr_i(ier_wr),
        .line_stat_i(lstat), .rx_count_i(cnt), .rx_trig_i(trig),
        .fifo_en_i(fifo_en), .tmo_pend_i(tmo), .tx_set_i(tx_set),
        .tx_hold_empty_i(hold_empty), .thr_wr_i(thr_wr),
        .msr_delta_i(delta), .iir_rd_i(iir_rd), .iir_o(iir), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    // Expected identification nibble from the requirements.
    function automatic logic [3:0] model(input logic [3:0] e, input logic [4:0] ls,
            input logic fe, input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] t,
            input logic to, input logic pend, input logic [3:0] d);
        if (e[2] && ls[4:1] != 0)                       return 4'h6;
        if (e[0] && to)                                 return 4'hC;
        if (e[0] && ls[0] && (!fe || c >= t))           return 4'h4;
        if (e[1] && pend)                               return 4'h2;
        if (e[3] && d != 0)                             return 4'h0;
        return 4'h1;
    endfunction

    function automatic string tag_of(input logic [3:0] id);
        case (id)
            4'h6: return "R4/R2/R3";
            4'hC: return "R5/R2/R3";
            4'h4: return "R6/R2/R3";
            4'h2: return "R7/R2/R3";
            4'h0: return "R12/R3";
            default: return "R3";
        endcase
    endfunction

    // Clear the pending flag, then optionally set it; leaves one settle edge.
    task automatic set_pend(input logic p);
        thr_wr = 1'b1;
        @(negedge clk);
        thr_wr = 1'b0;
        tx_set = p;
        @(negedge clk);
        tx_set = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] exp_id;
        logic [3:0] errs [3];
        logic [CNT_W-1:0] cnts [3];
        errs[0] = 4'h0; errs[1] = 4'h1; errs[2] = 4'h8;
        cnts[0] = 5'd7; cnts[1] = 5'd8; cnts[2] = 5'd9;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 iir in reset", iir, 8'h01);
        chk("R1 irq in reset", {7'h0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        ier = 4'h2;
        @(negedge clk);
        chk("R1 pending clear after reset", iir, 8'h01);

        // Sweep
        for (int e = 0; e < 16; e++)
        for (int dr = 0; dr < 2; dr++)
        for (int es = 0; es < 3; es++)
        for (int fe = 0; fe < 2; fe++)
        for (int to = 0; to < 2; to++)
        for (int ci = 0; ci < 3; ci++)
        for (int p = 0; p < 2; p++)
        for (int dm = 0; dm < 2; dm++) begin
            ier = 4'(e);
            lstat = {errs[es], 1'(dr)};
            fifo_en = 1'(fe);
            tmo = 1'(to);
            cnt = cnts[ci];
            delta = dm ? 4'h4 : 4'h0;
            set_pend(1'(p));
            exp_id = model(ier, lstat, fifo_en, cnt, trig, tmo, 1'(p), delta);
            chk(tag_of(exp_id), iir, {fifo_en ? 2'b11 : 2'b00, 2'b00, exp_id});
            chk("R11 irq", {7'h0, irq}, {7'h0, exp_id != 4'h1});
            if (fe == 1 && e == 0) chk("R10 marker", {6'h0, iir[7:6]}, 8'h03);
        end

        // R8: read while transmit-empty shown
        ier = 4'h2; lstat = 5'h0; tmo = 1'b0; delta = 4'h0; fifo_en = 1'b0;
        set_pend(1'b1);
        iir_rd = 1'b1;
        #1;
        chk("R8 value on read cycle", iir, 8'h02);
        @(negedge clk);
        iir_rd = 1'b0;
        chk("R8 cleared after read", iir, 8'h01);
        @(negedge clk);
        chk("R8/R11 irq drops", {7'h0, irq}, 8'h00);

        // R8: read while line status shown keeps the flag
        ier = 4'h6; lstat = 5'h04;
        set_pend(1'b1);
        iir_rd = 1'b1;
        @(negedge clk);
        iir_rd = 1'b0;
        lstat = 5'h0;
        #1;
        chk("R8 flag kept under higher cause", iir, 8'h02);

        // R7: set wins over holding write
        @(negedge clk);
        ier = 4'h2;
        set_pend(1'b0);
        tx_set = 1'b1; thr_wr = 1'b1;
        @(negedge clk);
        tx_set = 1'b0; thr_wr = 1'b0;
        chk("R7 set beats clear", iir, 8'h02);

        // R9: enable write re-arms only when holding empty
        set_pend(1'b0);
        hold_empty = 1'b0; ier_wr = 1'b1;
        @(negedge clk);
        ier_wr = 1'b0;
        chk("R9 no rearm when not empty", iir, 8'h01);
        hold_empty = 1'b1; ier_wr = 1'b1;
        @(negedge clk);
        ier_wr = 1'b0;
        chk("R9 rearm when empty", iir, 8'h02);
        set_pend(1'b0);

        // R11: one-cycle lag of the request line
        ier = 4'h8; delta = 4'h0;
        @(negedge clk);
        @(negedge clk);
        delta = 4'h1;
        #1;
        chk("R12 modem id", iir, 8'h00);
        chk("R11 irq not yet", {7'h0, irq}, 8'h00);
        @(negedge clk);
        chk("R11 irq after edge", {7'h0, irq}, 8'h01);

        // R4: data ready alone is not a line status cause
        ier = 4'h4; delta = 4'h0; lstat = 5'h01;
        #1;
        chk("R4 data ready alone", iir, 8'h01);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule